// File: doc/BRIEF.md
# Masked Header Field Packet Filter

This block watches a captured Ethernet frame that arrives as a stream of 16-bit words, with a start marker on the first word and an end marker on the last. While the words pass, it picks out the link, network and transport header fields. When the frame ends, it compares each of those fields with a programmed rule. The block sits beside a capture path and tells the logic downstream whether the frame just seen should be kept. The frame data itself does not pass through the block.

A rule is loaded through a small register-write port. Each field gets a value and a mask. One control word holds a bit for each field that turns that field's comparison on, and a bit that marks the rule as loaded.

The parser handles an optional 802.1Q tag, IPv4 headers from 5 to 15 words of 32 bits, and TCP or UDP port numbers. A separate pulse marks the word on which header parsing finished.

Top module: `hdr_rule_filter`

## Requirements
- R1: While reset is held and after it is released, `match_pulse` and `hdr_done` are 0. The rule resets to "not loaded", with every field disabled.
- R2: Fields are numbered as follows: 0 destination MAC (words 0..2, most significant first), 1 source MAC (words 3..5), 2 VLAN TCI, 3 EtherType, 4 IP protocol, 5 IPv4 source, 6 IPv4 destination, 7 L4 source port, 8 L4 destination port. An enabled field matches when (captured AND mask) equals (value AND mask).
- R3: Rule address 0 holds the field-enable bits in bits 8:0 (bit i for field i) and the rule-loaded flag in bit 31. A disabled field never affects the result, so a loaded rule with no field enabled matches every frame.
- R4: If word 6 equals 0x8100, word 7 is the TCI and word 8 is the EtherType. Otherwise word 6 is the EtherType.
- R5: IPv4 fields are parsed only when the EtherType is 0x0800. Within the IP header, word 0 bits 11:8 give the header length in 32-bit units. The protocol is the low byte of IP word 4. The source address is IP words 6..7 and the destination address is IP words 8..9.
- R6: Ports are parsed only when the protocol is 0x06 or 0x11. The source port is IP word 2*length and the destination port is the word after it, so IP options are skipped.
- R7: An enabled field that the frame does not carry counts as a mismatch. Examples are a TCI with no tag, IP fields in a non-IPv4 frame, and ports in a frame that is neither TCP nor UDP.
- R8: The IP protocol is always compared exactly. Writes to its mask words have no effect.
- R9: For field f, address 1+4f+s writes the value low 32 bits (s=0), the value bits 47:32 (s=1), the mask low 32 bits (s=2) or the mask bits 47:32 (s=3). A rule write is ignored while a frame is in progress (between its start word and its end word) or while a data word is valid in the same cycle.
- R10: `match_pulse` is 1 for exactly the one cycle after the end word, and only if the rule is loaded and every enabled field matches. A start word after that clears the parse state for the next frame.
- R11: `hdr_done` pulses for one cycle after the last header word that applies. That word is the EtherType for a frame that is not IPv4, IP word 9 for IPv4 that is neither TCP nor UDP, and the destination port word for TCP or UDP. A frame that ends before that word gives no pulse.
- R12: When the rule-loaded flag is 0, `match_pulse` stays 0 whatever the fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | A frame word is present on `in_data` |
| in_sof | input | 1 | The word is the first word of a frame |
| in_eof | input | 1 | The word is the last word of a frame |
| in_data | input | 16 | Frame word, with the earlier byte in bits 15:8 |
| cfg_we | input | 1 | Rule write strobe |
| cfg_addr | input | 6 | Rule register address |
| cfg_wdata | input | 32 | Rule write data |
| match_pulse | output | 1 | The frame just ended matched the rule |
| hdr_done | output | 1 | Header parsing completed on the previous word |

## Verification
The assertions check on every cycle the properties that hold by themselves:
- a match pulse only ever follows an end word;
- a match never happens while an enabled field is still missing;
- port fields never appear without a protocol field;
- header-done pulses follow a valid word and never come back to back;
- the stored rule stays unchanged while the block is locked.

Only the bench scenarios can show the rest:
- that the right words are picked at each offset, with and without a tag and with IP options;
- that masked comparisons give the right answer;
- that truncated frames give no header-done pulse;
- that a write attempted during a frame leaves the next frame's result unchanged.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int NF     = 9;
  localparam int DATA_W = 16;
  localparam int FLD_W  = 48;

  localparam int F_DST   = 0;
  localparam int F_SRC   = 1;
  localparam int F_TCI   = 2;
  localparam int F_ETY   = 3;
  localparam int F_PROTO = 4;
  localparam int F_SIP   = 5;
  localparam int F_DIP   = 6;
  localparam int F_SP    = 7;
  localparam int F_DP    = 8;

  localparam logic [DATA_W-1:0] TPID_VLAN = 16'h8100;
  localparam logic [DATA_W-1:0] ETY_IPV4  = 16'h0800;
  localparam logic [7:0]        P_TCP     = 8'h06;
  localparam logic [7:0]        P_UDP     = 8'h11;

  typedef logic [FLD_W-1:0]          fld_t;
  typedef logic [NF-1:0][FLD_W-1:0]  fld_arr_t;

  // bits a field really occupies inside its 48-bit lane
  function automatic fld_t width_mask(int f);
    case (f)
      F_DST, F_SRC: return {FLD_W{1'b1}};
      F_PROTO:      return {{(FLD_W-8){1'b0}}, 8'hFF};
      F_SIP, F_DIP: return {{(FLD_W-32){1'b0}}, 32'hFFFF_FFFF};
      default:      return {{(FLD_W-16){1'b0}}, 16'hFFFF};
    endcase
  endfunction
endpackage

// File: rtl/hrf_parser.sv
module hrf_parser
  import hrf_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  output fld_arr_t          cap,
  output logic [NF-1:0]     have,
  output logic              hdr_done,
  output logic              eval,
  output logic              busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  logic [IDX_W-1:0] wcnt_q, wcnt_n, idx, base, rel, l4off;
  logic             vlan_q, vlan_n, vlan_b;
  logic             ip_q, ip_n, ip_b;
  logic             l4_q, l4_n, l4_b;
  logic [3:0]       ihl_q, ihl_n, ihl_b, ihl_eff;
  fld_arr_t         cap_q, cap_n;
  logic [NF-1:0]    have_q, have_n;
  logic             frame_q, frame_n;
  logic             done_c, done_q, eval_q, in_ip;

  always_comb begin
    idx     = in_sof ? '0 : wcnt_q;
    vlan_b  = !in_sof && vlan_q;
    ip_b    = !in_sof && ip_q;
    l4_b    = !in_sof && l4_q;
    ihl_b   = in_sof ? 4'd5 : ihl_q;
    ihl_eff = (ihl_b < 4'd5) ? 4'd5 : ihl_b;
    base    = vlan_b ? IDX_W'(9) : IDX_W'(7);
    in_ip   = (idx >= base);
    rel     = idx - base;
    l4off   = IDX_W'({ihl_eff, 1'b0});

    wcnt_n  = wcnt_q;
    vlan_n  = vlan_q;
    ip_n    = ip_q;
    l4_n    = l4_q;
    ihl_n   = ihl_q;
    cap_n   = cap_q;
    have_n  = have_q;
    frame_n = frame_q;
    done_c  = 1'b0;

    if (in_vld) begin
      wcnt_n  = (idx == LAST_IDX) ? idx : idx + IDX_W'(1);
      vlan_n  = vlan_b;
      ip_n    = ip_b;
      l4_n    = l4_b;
      ihl_n   = ihl_b;
      have_n  = in_sof ? '0 : have_q;
      frame_n = !in_eof;

      case (idx)
        IDX_W'(0): cap_n[F_DST][47:32] = in_data;
        IDX_W'(1): cap_n[F_DST][31:16] = in_data;
        IDX_W'(2): begin cap_n[F_DST][15:0] = in_data; have_n[F_DST] = 1'b1; end
        IDX_W'(3): cap_n[F_SRC][47:32] = in_data;
        IDX_W'(4): cap_n[F_SRC][31:16] = in_data;
        IDX_W'(5): begin cap_n[F_SRC][15:0] = in_data; have_n[F_SRC] = 1'b1; end
        IDX_W'(6): begin
          if (in_data == TPID_VLAN) begin
            vlan_n = 1'b1;
          end else begin
            cap_n[F_ETY]  = FLD_W'(in_data);
            have_n[F_ETY] = 1'b1;
            ip_n          = (in_data == ETY_IPV4);
            done_c        = (in_data != ETY_IPV4);
          end
        end
        IDX_W'(7): if (vlan_b) begin
          cap_n[F_TCI]  = FLD_W'(in_data);
          have_n[F_TCI] = 1'b1;
        end
        IDX_W'(8): if (vlan_b) begin
          cap_n[F_ETY]  = FLD_W'(in_data);
          have_n[F_ETY] = 1'b1;
          ip_n          = (in_data == ETY_IPV4);
          done_c        = (in_data != ETY_IPV4);
        end
        default: ;
      endcase

      if (ip_b && in_ip) begin
        if (rel == IDX_W'(0)) ihl_n = in_data[11:8];
        if (rel == IDX_W'(4)) begin
          cap_n[F_PROTO]  = FLD_W'(in_data[7:0]);
          have_n[F_PROTO] = 1'b1;
          l4_n = (in_data[7:0] == P_TCP) || (in_data[7:0] == P_UDP);
        end
        if (rel == IDX_W'(6)) cap_n[F_SIP][31:16] = in_data;
        if (rel == IDX_W'(7)) begin cap_n[F_SIP][15:0] = in_data; have_n[F_SIP] = 1'b1; end
        if (rel == IDX_W'(8)) cap_n[F_DIP][31:16] = in_data;
        if (rel == IDX_W'(9)) begin
          cap_n[F_DIP][15:0] = in_data;
          have_n[F_DIP]      = 1'b1;
          if (!l4_b) done_c = 1'b1;
        end
        if (l4_b && rel == l4off) begin
          cap_n[F_SP]  = FLD_W'(in_data);
          have_n[F_SP] = 1'b1;
        end
        if (l4_b && rel == l4off + IDX_W'(1)) begin
          cap_n[F_DP]  = FLD_W'(in_data);
          have_n[F_DP] = 1'b1;
          done_c       = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      vlan_q  <= 1'b0;
      ip_q    <= 1'b0;
      l4_q    <= 1'b0;
      ihl_q   <= 4'd5;
      have_q  <= '0;
      frame_q <= 1'b0;
      done_q  <= 1'b0;
      eval_q  <= 1'b0;
    end else begin
      wcnt_q  <= wcnt_n;
      vlan_q  <= vlan_n;
      ip_q    <= ip_n;
      l4_q    <= l4_n;
      ihl_q   <= ihl_n;
      have_q  <= have_n;
      frame_q <= frame_n;
      done_q  <= in_vld && done_c;
      eval_q  <= in_vld && in_eof;
    end
  end

  // datapath capture: clock-enabled, qualified by have_q
  always_ff @(posedge clk) begin
    if (in_vld) cap_q <= cap_n;
  end

  assign cap      = cap_q;
  assign have     = have_q;
  assign hdr_done = done_q;
  assign eval     = eval_q;
  assign busy     = frame_q || in_vld;

  // R6: a port field can only have been taken after the protocol
  a_r6_ports_need_proto: assert property (@(posedge clk) disable iff (!rst_n)
    have_q[F_DP] |-> have_q[F_PROTO]);
  // R11: parsing completes at most once per frame, never on consecutive cycles
  a_r11_done_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |=> !hdr_done);
  // R11: completion always follows an accepted word
  a_r11_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |-> $past(in_vld));
endmodule

// File: rtl/hrf_rules.sv
module hrf_rules
  import hrf_pkg::*;
#(
  parameter int CFG_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              lock,
  output fld_arr_t          val,
  output fld_arr_t          msk,
  output logic [NF-1:0]     en,
  output logic              present
);
  localparam int FSEL_W = CFG_AW - 2;

  fld_arr_t          val_q, val_n, msk_q, msk_n;
  logic [NF-1:0]     en_q, en_n;
  logic              present_q, present_n;
  logic              take;
  logic [CFG_AW-1:0] rel_a;
  logic [FSEL_W-1:0] fsel;
  logic [1:0]        wsel;

  always_comb begin
    take      = wr_en && !lock;
    rel_a     = wr_addr - CFG_AW'(1);
    fsel      = rel_a[CFG_AW-1:2];
    wsel      = rel_a[1:0];
    val_n     = val_q;
    msk_n     = msk_q;
    en_n      = en_q;
    present_n = present_q;
    if (take && wr_addr == '0) begin
      en_n      = wr_data[NF-1:0];
      present_n = wr_data[31];
    end
    for (int f = 0; f < NF; f++) begin
      if (take && wr_addr != '0 && fsel == FSEL_W'(f)) begin
        case (wsel)
          2'd0: val_n[f][31:0]  = wr_data;
          2'd1: val_n[f][47:32] = wr_data[15:0];
          2'd2: msk_n[f][31:0]  = wr_data;
          default: msk_n[f][47:32] = wr_data[15:0];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q     <= '0;
      msk_q     <= '0;
      en_q      <= '0;
      present_q <= 1'b0;
    end else begin
      val_q     <= val_n;
      msk_q     <= msk_n;
      en_q      <= en_n;
      present_q <= present_n;
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_lane
    assign val[g] = val_q[g] & width_mask(g);
    if (g == F_PROTO) begin : g_exact
      assign msk[g] = width_mask(g);
    end else begin : g_masked
      assign msk[g] = msk_q[g] & width_mask(g);
    end
  end

  assign en      = en_q;
  assign present = present_q;

  // R9: nothing in the rule moves while a frame is being parsed
  a_r9_rule_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(en_q) && $stable(present_q) && $stable(val_q) && $stable(msk_q)));
endmodule

// File: rtl/hrf_match.sv
module hrf_match
  import hrf_pkg::*;
(
  input  fld_arr_t      cap,
  input  logic [NF-1:0] have,
  input  fld_arr_t      val,
  input  fld_arr_t      msk,
  input  logic [NF-1:0] en,
  input  logic          present,
  input  logic          eval,
  output logic          match
);
  logic [NF-1:0] ok;

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign ok[g] = !en[g] || (have[g] && (((cap[g] ^ val[g]) & msk[g]) == '0));
  end

  assign match = eval && present && (&ok);
endmodule

// File: rtl/hdr_rule_filter.sv
module hdr_rule_filter
  import hrf_pkg::*;
#(
  parameter int CFG_AW = 6,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [15:0]       in_data,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              match_pulse,
  output logic              hdr_done
);
  fld_arr_t      cap, val, msk;
  logic [NF-1:0] have, en;
  logic          present, eval, busy;

  hrf_parser #(.IDX_W(IDX_W)) u_parser (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .cap(cap), .have(have), .hdr_done(hdr_done),
    .eval(eval), .busy(busy)
  );

  hrf_rules #(.CFG_AW(CFG_AW)) u_rules (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .lock(busy), .val(val), .msk(msk), .en(en),
    .present(present)
  );

  hrf_match u_match (
    .cap(cap), .have(have), .val(val), .msk(msk), .en(en),
    .present(present), .eval(eval), .match(match_pulse)
  );

  // R10: a match is only reported in the cycle after an end word
  a_r10_match_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(in_vld && in_eof));
  // R7: every enabled field was really present in the frame that matched
  a_r7_enabled_fields_seen: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> ((en & ~have) == '0));
endmodule

// File: tb/hdr_rule_filter_test.sv
`timescale 1ns/1ps
module hdr_rule_filter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld, in_sof, in_eof;
  logic [15:0] in_data;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        match_pulse, hdr_done;

  always #2.5 clk = ~clk;

  hdr_rule_filter uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .match_pulse(match_pulse), .hdr_done(hdr_done)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  bit    pend_m = 0, pend_d = 0;
  string pend_tag = "R1";

  logic [47:0] rv[9];
  logic [47:0] rm[9];
  logic [8:0]  ren;
  bit          rpres;
  logic [15:0] fq[$];

  function automatic logic [47:0] wm(int f);
    case (f)
      0, 1:    return 48'hFFFF_FFFF_FFFF;
      4:       return 48'hFF;
      5, 6:    return 48'hFFFF_FFFF;
      default: return 48'hFFFF;
    endcase
  endfunction

  function automatic logic [5:0] fa(int f, int s);
    return 6'(1 + 4 * f + s);
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // one clock: drive, then at mid-cycle compare the response to the previous cycle
  task automatic cyc(input logic v, input logic s, input logic e, input logic [15:0] d,
                     input logic we, input logic [5:0] a, input logic [31:0] wd,
                     input logic em, input logic ed, input string tag);
    @(posedge clk); #1;
    in_vld = v; in_sof = s; in_eof = e; in_data = d;
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    @(negedge clk);
    chk(pend_tag, "match_pulse", match_pulse, pend_m);
    chk(pend_tag, "hdr_done", hdr_done, pend_d);
    pend_m = em; pend_d = ed; pend_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 16'h0, 0, 6'h0, 32'h0, 0, 0, pend_tag);
  endtask

  task automatic model_write(input logic [5:0] a, input logic [31:0] d);
    if (a == 6'd0) begin
      ren = d[8:0]; rpres = d[31];
    end else if (a <= 6'd36) begin
      int f = (int'(a) - 1) / 4;
      int s = (int'(a) - 1) % 4;
      case (s)
        0: rv[f][31:0]  = d;
        1: rv[f][47:32] = d[15:0];
        2: rm[f][31:0]  = d;
        default: rm[f][47:32] = d[15:0];
      endcase
    end
  endtask

  task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
    cyc(0, 0, 0, 16'h0, 1, a, d, 0, 0, "R9");
    model_write(a, d);
  endtask

  task automatic build(input logic [47:0] d, input logic [47:0] s, input bit vl,
                       input logic [15:0] tci, input logic [15:0] et, input logic [3:0] ihl,
                       input logic [7:0] pr, input logic [31:0] si, input logic [31:0] di,
                       input logic [15:0] sp, input logic [15:0] dp, input int pay);
    int eff;
    fq.delete();
    fq.push_back(d[47:32]); fq.push_back(d[31:16]); fq.push_back(d[15:0]);
    fq.push_back(s[47:32]); fq.push_back(s[31:16]); fq.push_back(s[15:0]);
    if (vl) begin fq.push_back(16'h8100); fq.push_back(tci); end
    fq.push_back(et);
    if (et == 16'h0800) begin
      eff = (ihl < 5) ? 5 : int'(ihl);
      fq.push_back({4'h4, ihl, 8'h00});
      fq.push_back(16'd60);
      fq.push_back(16'h1234);
      fq.push_back(16'h0000);
      fq.push_back({8'h40, pr});
      fq.push_back(16'hBEEF);
      fq.push_back(si[31:16]); fq.push_back(si[15:0]);
      fq.push_back(di[31:16]); fq.push_back(di[15:0]);
      for (int k = 10; k < 2 * eff; k++) fq.push_back(16'h0700 + 16'(k));
      if (pr == 8'h06 || pr == 8'h11) begin fq.push_back(sp); fq.push_back(dp); end
    end
    for (int k = 0; k < pay; k++) fq.push_back(16'hA500 + 16'(k));
  endtask

  // behavioural reference: field extraction by index arithmetic on the queue
  task automatic ref_eval(output bit m, output int di);
    logic [47:0] c[9];
    bit          h[9];
    int          n, et_i, b, eff;
    bit          vl, ip, l4;
    logic [47:0] mk;
    n = fq.size();
    for (int f = 0; f < 9; f++) begin c[f] = '0; h[f] = 0; end
    di = -1; ip = 0; l4 = 0; eff = 5;
    if (n > 2) begin h[0] = 1; c[0] = {fq[0], fq[1], fq[2]}; end
    if (n > 5) begin h[1] = 1; c[1] = {fq[3], fq[4], fq[5]}; end
    vl   = (n > 6) && (fq[6] == 16'h8100);
    et_i = vl ? 8 : 6;
    if (vl && n > 7) begin h[2] = 1; c[2] = 48'(fq[7]); end
    if (n > et_i) begin
      h[3] = 1; c[3] = 48'(fq[et_i]);
      ip = (fq[et_i] == 16'h0800);
      if (!ip) di = et_i;
    end
    b = et_i + 1;
    if (ip) begin
      if (n > b) eff = (fq[b][11:8] < 5) ? 5 : int'(fq[b][11:8]);
      if (n > b + 4) begin
        h[4] = 1; c[4] = 48'(fq[b+4][7:0]);
        l4 = (fq[b+4][7:0] == 8'h06) || (fq[b+4][7:0] == 8'h11);
      end
      if (n > b + 7) begin h[5] = 1; c[5] = 48'({fq[b+6], fq[b+7]}); end
      if (n > b + 9) begin h[6] = 1; c[6] = 48'({fq[b+8], fq[b+9]}); end
      if (!l4 && n > b + 9) di = b + 9;
      if (l4) begin
        if (n > b + 2 * eff) begin h[7] = 1; c[7] = 48'(fq[b + 2 * eff]); end
        if (n > b + 2 * eff + 1) begin
          h[8] = 1; c[8] = 48'(fq[b + 2 * eff + 1]); di = b + 2 * eff + 1;
        end
      end
    end
    m = rpres;
    for (int f = 0; f < 9; f++) begin
      if (ren[f]) begin
        mk = (f == 4) ? 48'hFF : (rm[f] & wm(f));
        if (!h[f] || (((c[f] ^ rv[f]) & mk) != '0)) m = 0;
      end
    end
  endtask

  // mode 1: idle cycle carrying a write before word 'at'; mode 2: write on word 'at'
  task automatic send(input string tag, input int mode = 0, input int at = 0,
                      input logic [5:0] wa = 6'h0, input logic [31:0] wd = 32'h0);
    bit m;
    int di, n;
    ref_eval(m, di);
    n = fq.size();
    for (int i = 0; i < n; i++) begin
      bit last;
      last = (i == n - 1);
      if (mode == 1 && i == at) cyc(0, 0, 0, 16'h0, 1, wa, wd, 0, 0, tag);
      cyc(1, i == 0, last, fq[i], (mode == 2 && i == at), wa, wd, m && last, i == di, tag);
    end
  endtask

  localparam logic [47:0] DA = 48'h0200_1122_3344;
  localparam logic [47:0] SA = 48'h0A0B_0C0D_0E0F;

  initial begin
    for (int f = 0; f < 9; f++) begin rv[f] = '0; rm[f] = '0; end
    ren = '0; rpres = 0;
    rst_n = 1'b0;
    in_vld = 0; in_sof = 0; in_eof = 0; in_data = '0;
    cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "match_pulse in reset", match_pulse, 1'b0);
    chk("R1", "hdr_done in reset", hdr_done, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(3);

    // R1: after reset nothing enabled and rule not loaded -> no match
    build(DA, SA, 0, 0, 16'h0800, 5, 8'h06, 32'hC0A8_0137, 32'h0A00_0005, 16'd1000, 16'd80, 4);
    send("R1");
    // R12: all fields enabled but not loaded
    cfg_wr(6'd0, 32'h0000_01FF);
    send("R12");
    idle(2);

    // R2: exact destination MAC
    cfg_wr(fa(0, 0), 32'h1122_3344); cfg_wr(fa(0, 1), 32'h0000_0200);
    cfg_wr(fa(0, 2), 32'hFFFF_FFFF); cfg_wr(fa(0, 3), 32'h0000_FFFF);
    cfg_wr(6'd0, 32'h8000_0001);
    send("R2");
    build(48'h0200_1122_3345, SA, 0, 0, 16'h0806, 5, 0, 0, 0, 0, 0, 20);
    send("R2");
    // R2: masked, upper 16 bits only
    cfg_wr(fa(0, 2), 32'h0000_0000);
    build(48'h0200_9999_9999, SA, 0, 0, 16'h0806, 5, 0, 0, 0, 0, 0, 20);
    send("R2");
    build(48'h0300_1122_3344, SA, 0, 0, 16'h0806, 5, 0, 0, 0, 0, 0, 20);
    send("R2");
    idle(2);

    // R3: loaded, nothing enabled -> everything matches, even a one-word frame (R10)
    cfg_wr(6'd0, 32'h8000_0000);
    build(48'hFFFF_FFFF_FFFF, SA, 0, 0, 16'h88CC, 5, 0, 0, 0, 0, 0, 10);
    send("R3");
    fq.delete(); fq.push_back(16'h1234);
    send("R10");
    send("R10");
    idle(2);

    // R4: VLAN VID 100 and IPv4 ethertype
    cfg_wr(fa(2, 0), 32'h0000_0064); cfg_wr(fa(2, 2), 32'h0000_0FFF);
    cfg_wr(fa(3, 0), 32'h0000_0800); cfg_wr(fa(3, 2), 32'h0000_FFFF);
    cfg_wr(6'd0, 32'h8000_000C);
    build(DA, SA, 1, 16'hA064, 16'h0800, 5, 8'h11, 32'h0101_0101, 32'h0202_0202, 16'd53, 16'd53, 6);
    send("R4");
    build(DA, SA, 1, 16'hA065, 16'h0800, 5, 8'h11, 32'h0101_0101, 32'h0202_0202, 16'd53, 16'd53, 6);
    send("R4");
    // R7: untagged frame, TCI enabled but absent
    build(DA, SA, 0, 0, 16'h0800, 5, 8'h11, 32'h0101_0101, 32'h0202_0202, 16'd53, 16'd53, 6);
    send("R7");
    idle(2);

    // R5 / R6: source subnet, exact destination, destination port 80
    cfg_wr(fa(5, 0), 32'hC0A8_0100); cfg_wr(fa(5, 2), 32'hFFFF_FF00);
    cfg_wr(fa(6, 0), 32'h0A00_0005); cfg_wr(fa(6, 2), 32'hFFFF_FFFF);
    cfg_wr(fa(8, 0), 32'h0000_0050); cfg_wr(fa(8, 2), 32'h0000_FFFF);
    cfg_wr(6'd0, 32'h8000_0160);
    build(DA, SA, 0, 0, 16'h0800, 5, 8'h06, 32'hC0A8_0137, 32'h0A00_0005, 16'd4000, 16'd80, 8);
    send("R5");
    build(DA, SA, 0, 0, 16'h0800, 7, 8'h06, 32'hC0A8_0101, 32'h0A00_0005, 16'd4000, 16'd80, 3);
    send("R6");
    build(DA, SA, 0, 0, 16'h0800, 5, 8'h06, 32'hC0A8_0237, 32'h0A00_0005, 16'd4000, 16'd80, 3);
    send("R5");
    build(DA, SA, 1, 16'h0001, 16'h0800, 15, 8'h11, 32'hC0A8_01FE, 32'h0A00_0005, 16'd9, 16'd80, 2);
    send("R4");
    build(DA, SA, 0, 0, 16'h0800, 5, 8'h11, 32'hC0A8_0137, 32'h0A00_0005, 16'd9, 16'd81, 2);
    send("R6");
    // R7: ICMP has no ports; ARP has no IP fields
    build(DA, SA, 0, 0, 16'h0800, 5, 8'h01, 32'hC0A8_0137, 32'h0A00_0005, 0, 0, 12);
    send("R7");
    build(DA, SA, 0, 0, 16'h0806, 5, 0, 0, 0, 0, 0, 20);
    send("R7");
    // R11: truncated inside the IP header -> no completion, no match
    build(DA, SA, 0, 0, 16'h0800, 5, 8'h06, 32'hC0A8_0137, 32'h0A00_0005, 16'd4000, 16'd80, 0);
    while (fq.size() > 12) void'(fq.pop_back());
    send("R11");
    idle(2);

    // R8: protocol compare stays exact even after zeroing its mask words
    cfg_wr(fa(4, 0), 32'h0000_0006);
    cfg_wr(fa(4, 2), 32'h0000_0000); cfg_wr(fa(4, 3), 32'h0000_0000);
    cfg_wr(6'd0, 32'h8000_0010);
    build(DA, SA, 0, 0, 16'h0800, 5, 8'h11, 32'h0, 32'h0, 16'd1, 16'd2, 4);
    send("R8");
    build(DA, SA, 0, 0, 16'h0800, 5, 8'h06, 32'h0, 32'h0, 16'd1, 16'd2, 4);
    send("R8");
    idle(1);

    // R9: writes during a frame (gap cycle, and on the start word) are dropped
    build(DA, SA, 0, 0, 16'h0800, 5, 8'h11, 32'h0, 32'h0, 16'd1, 16'd2, 4);
    send("R9", 1, 3, 6'd0, 32'h8000_0000);
    send("R9", 2, 0, 6'd0, 32'h8000_0000);
    idle(1);
    send("R9");
    idle(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule